// File: doc/BRIEF.md
# Button-Cycled Rate Strobe Generator

This block paces a slow state machine, such as an LED chaser, from a fast system clock. It does this with a one-clock enable strobe, not with a derived clock. A free-running counter counts system clocks. When the counter reaches the divider value for the current speed, the block raises the strobe for one cycle and the counter starts again from zero. The logic downstream advances only in cycles where the strobe is high.

A raw, active-low push-button selects the speed. The button input is synchronised, debounced and reduced to a single press event. Each press advances a 2-bit speed index. The strobe rate steps through the base rate, two times, four times and eight times the base rate, and then returns to the base rate. The strobe period at speed index k is `BASE_PERIOD >> k` clocks. `BASE_PERIOD` is a multiple of 8. When `BASE_PERIOD` is 8, the fastest speed has a divider of zero and the block strobes on every clock.

Top module: `rate_strobe_gen`

## Requirements
- R1: While reset is asserted, `strobe_o` is 0 and `speed_o` is 0, which is the base rate.
- R2: At speed index 0, `strobe_o` goes high for exactly one clock once every `BASE_PERIOD` clocks and is low in all other cycles.
- R3: Each accepted press adds one to `speed_o` (encoding: 0 = base rate, 1 = 2x, 2 = 4x, 3 = 8x). The strobe period then becomes `BASE_PERIOD >> speed_o` clocks.
- R4: A press at speed index 3 wraps `speed_o` back to 0, and the strobe period returns to `BASE_PERIOD`.
- R5: With `BASE_PERIOD` = 8, speed index 3 has a divider of zero, and `strobe_o` is high on every clock.
- R6: Low pulses on `btn_ni` that are shorter than `DEBOUNCE_CYCLES` clocks leave `speed_o` and the strobe period unchanged.
- R7: A press that is held for several debounce times advances `speed_o` exactly once.
- R8: When the speed index changes, the counter is cleared. The first strobe then appears exactly one new period after the change, and no strobe is produced in the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| btn_ni | input | 1 | Raw speed button, low while pressed |
| strobe_o | output | 1 | One-clock enable strobe |
| speed_o | output | 2 | Current speed index, 0 to 3 |

## Verification
The bench drives clean long presses through all four speeds and the wrap. It measures the spacing between strobes at each speed, so that a wrong divider or a wrong shift shows up as a period error. It also measures the delay from each speed change to the first strobe, which separates a design that clears its counter from one that lets a stale count run on. A train of bounce pulses shorter than the debounce time must leave speed and period unchanged. A single press held much longer than the debounce time must give exactly one step; this catches level-triggered or retriggering press logic.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned SPEED_W    = 2;
  localparam int unsigned NUM_SPEEDS = 1 << SPEED_W;
  typedef logic [SPEED_W-1:0] speed_t;
endpackage

// File: rtl/rsg_btn_cond.sv
// Synchroniser, stable-level debouncer and press (falling edge) detector.
module rsg_btn_cond #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYC     = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic press_o
);
  localparam int unsigned DCNT_W = $clog2(DEB_CYC + 1);
  localparam logic [DCNT_W-1:0] DEB_LAST = DCNT_W'(DEB_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw;
  logic                   lvl_q, lvl_n;
  logic [DCNT_W-1:0]      dcnt_q, dcnt_n;
  logic                   press_q, press_n;

  assign raw = sync_q[SYNC_STAGES-1];

  always_comb begin
    lvl_n   = lvl_q;
    dcnt_n  = dcnt_q;
    press_n = 1'b0;
    if (raw == lvl_q) begin
      dcnt_n = '0;
    end else if (dcnt_q == DEB_LAST) begin
      lvl_n   = raw;
      dcnt_n  = '0;
      press_n = ~raw;
    end else begin
      dcnt_n = dcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      lvl_q   <= 1'b1;
      dcnt_q  <= '0;
      press_q <= 1'b0;
    end else begin
      sync_q[0] <= btn_ni;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      lvl_q   <= lvl_n;
      dcnt_q  <= dcnt_n;
      press_q <= press_n;
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/rsg_speed_sel.sv
// Wrapping speed index register, stepped by press events.
module rsg_speed_sel
  import rsg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   step_i,
  output speed_t speed_o
);
  speed_t speed_q, speed_n;

  always_comb begin
    speed_n = speed_q;
    if (step_i) speed_n = speed_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) speed_q <= '0;
    else         speed_q <= speed_n;
  end

  assign speed_o = speed_q;
endmodule

// File: rtl/rsg_strobe_div.sv
// Terminal-count divider; divider chosen per speed from a computed table.
module rsg_strobe_div
  import rsg_pkg::*;
#(
  parameter int unsigned BASE_PERIOD = 64,
  parameter int unsigned CNT_W       = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  speed_t           speed_i,
  input  logic             clr_i,
  output logic             strobe_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] div_o
);
  logic [CNT_W-1:0] div_tab [NUM_SPEEDS];

  for (genvar k = 0; k < NUM_SPEEDS; k++) begin : g_div
    localparam int unsigned DIVK = (BASE_PERIOD >> k) - 1;
    assign div_tab[k] = DIVK[CNT_W-1:0];
  end

  logic [CNT_W-1:0] div;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             stb_q, stb_n;

  assign div = div_tab[speed_i];

  always_comb begin
    cnt_n = cnt_q + 1'b1;
    stb_n = 1'b0;
    if (clr_i) begin
      cnt_n = '0;
    end else if (cnt_q == div) begin
      cnt_n = '0;
      stb_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      stb_q <= stb_n;
    end
  end

  assign strobe_o = stb_q;
  assign cnt_o    = cnt_q;
  assign div_o    = div;
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rsg_pkg::*;
#(
  parameter int unsigned BASE_PERIOD     = 64,
  parameter int unsigned DEBOUNCE_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_ni,
  output logic       strobe_o,
  output logic [1:0] speed_o
);
  localparam int unsigned CNT_W = (BASE_PERIOD > 2) ? $clog2(BASE_PERIOD) : 1;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic             press;
  speed_t           speed_q;
  logic [CNT_W-1:0] cnt_q, div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  rsg_btn_cond #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEB_CYC    (DEBOUNCE_CYCLES)
  ) btn_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .btn_ni (btn_ni),
    .press_o(press)
  );

  rsg_speed_sel spd_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .step_i (press),
    .speed_o(speed_q)
  );

  rsg_strobe_div #(
    .BASE_PERIOD(BASE_PERIOD),
    .CNT_W      (CNT_W)
  ) div_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .speed_i (speed_q),
    .clr_i   (press),
    .strobe_o(strobe_o),
    .cnt_o   (cnt_q),
    .div_o   (div_q)
  );

  assign speed_o = speed_q;
endmodule

// File: rtl/rate_strobe_chk.sv
module rate_strobe_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             press,
  input logic [1:0]       speed,
  input logic             strobe,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] div
);
  AST_SPEED_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    press |=> speed == 2'($past(speed) + 2'd1)); // R3
  AST_SPEED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    !press |=> $stable(speed)); // R6
  AST_PRESS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    press |=> !press); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt <= div); // R8
  AST_CLEAR_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    press |=> (cnt == '0) && !strobe); // R8
  AST_STROBE_AT_TERM: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt == div && !press) |=> strobe); // R2
  AST_STROBE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt != div || press) |=> !strobe); // R2
endmodule

bind rate_strobe_gen rate_strobe_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i (clk_i),
  .rst_n (rst_n_s),
  .press (press),
  .speed (speed_q),
  .strobe(strobe_o),
  .cnt   (cnt_q),
  .div   (div_q)
);

// File: tb/rate_strobe_gen_tb_top.sv
module rate_strobe_gen_tb_top;
  localparam int BASE = 8;
  localparam int DEB  = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       btn_n;
  logic       strobe;
  logic [1:0] speed;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  rate_strobe_gen #(
    .BASE_PERIOD    (BASE),
    .DEBOUNCE_CYCLES(DEB)
  ) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .btn_ni  (btn_n),
    .strobe_o(strobe),
    .speed_o (speed)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: queue the expected speed, then press and release cleanly.
  task automatic press_btn(int exp_speed, string tag);
    exp_q.push_back(exp_speed);
    @(negedge clk) btn_n = 1'b0;
    repeat (3*DEB) @(negedge clk);
    btn_n = 1'b1;
    repeat (2*DEB) @(negedge clk);
    check(int'(speed) == exp_speed, tag, int'(speed), exp_speed);
  endtask

  task automatic chk_period(int exp, string tag);
    int gap;
    do @(negedge clk); while (!strobe);
    for (int g = 0; g < 3; g++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!strobe);
      check(gap == exp, tag, gap, exp);
    end
  endtask

  // Monitor: pop expected speed on every change, then time first strobe (R8).
  logic [1:0] last_spd;
  bit         armed;
  int         since;
  always @(negedge clk) begin
    if (!rst_n) begin
      last_spd <= 2'd0;
      armed    <= 1'b0;
    end else begin
      if (speed != last_spd) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected change", int'(speed), int'(last_spd));
        else begin
          automatic int e = exp_q.pop_front();
          check(int'(speed) == e, "R3 speed step", int'(speed), e);
        end
        check(strobe == 1'b0, "R8 no strobe at change", int'(strobe), 0);
        armed <= 1'b1;
        since <= 0;
      end else if (armed) begin
        if (strobe) begin
          check(since + 1 == (BASE >> speed), "R8 first strobe delay", since + 1, BASE >> speed);
          armed <= 1'b0;
        end else since <= since + 1;
      end
      last_spd <= speed;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    btn_n = 1'b1;
    repeat (5) @(negedge clk);
    check(strobe == 1'b0, "R1 strobe in reset", int'(strobe), 0);
    check(speed == 2'd0, "R1 speed in reset", int'(speed), 0);
    rst_n = 1'b1;

    chk_period(BASE, "R2 base period");
    press_btn(1, "R3 press to 2x");
    chk_period(BASE/2, "R3 period 2x");
    press_btn(2, "R3 press to 4x");
    chk_period(BASE/4, "R3 period 4x");
    press_btn(3, "R7 held press single step");
    chk_period(BASE/8, "R5 divider zero");
    press_btn(0, "R4 wrap to base");
    chk_period(BASE, "R4 base after wrap");

    // Bounce train: pulses shorter than the debounce time
    for (int b = 0; b < 6; b++) begin
      @(negedge clk) btn_n = 1'b0;
      repeat (DEB/2 - 1) @(negedge clk);
      btn_n = 1'b1;
      repeat (DEB/2 - 1) @(negedge clk);
    end
    repeat (3*DEB) @(negedge clk);
    check(speed == 2'd0, "R6 bounce ignored", int'(speed), 0);
    chk_period(BASE, "R6 period after bounce");

    check(exp_q.size() == 0, "R3 all steps seen", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule